// File: doc/BRIEF.md
# ADC Control and Result Register Interface

This block is the processor-facing register set in front of an analog-to-digital converter. Software writes a control register to enable the converter, choose the clock prescaler and start either one conversion or a free-running sequence. It writes a select register to choose the input channel and the result alignment. It reads the 10-bit result back as two bytes, and it either polls a completion flag or takes an interrupt. The converter is modelled here by a stub engine. The stub captures the `analog_in` code when a conversion starts and returns that code after 13 ADC clock ticks.

The block drives the engine's start pulse and the channel the engine converts. Channel changes reach the engine only when a conversion starts. In free-running mode the next conversion starts in the same cycle that the completion flag rises, so a channel change written after the flag takes effect one conversion later. Reading the low result byte locks the result pair until the high byte is read. A low and high read pair therefore always belongs to the same conversion.

Register map (byte wide, selected by `bus_addr`):

| Address | Contents |
|---|---|
| 0 | Control: bit0 enable, bit1 start/busy, bit2 free-run, bit3 completion flag, bit4 interrupt enable, bits 7:5 prescaler code |
| 1 | Select: bits 2:0 channel, bit 7 left adjust, bits 6:3 read back as written |
| 2 | Result low byte |
| 3 | Result high byte |

Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` is sampled.

Top module: `adc_regif`

## Requirements
- R1: When a conversion ends, the completion flag (control bit3) is 1 from the next clock onward, and the result pair holds the new code unless the pair is locked.
- R2: The completion flag is cleared by a pulse on `irq_ack`, or by a control write that has bit3 set to 1. A control write with bit3 set to 0 leaves the flag unchanged.
- R3: `irq` is 1 exactly when the completion flag, control bit4 and `gie` are all 1.
- R4: Prescaler codes 0 to 7 (control bits 7:5) divide the system clock by 2, 2, 4, 8, 16, 32, 64 and 128. A single conversion started by a control write raises `irq` 13*div+2 clocks after the clock that samples the write.
- R5: A read of address 2 locks the result pair until address 3 is read. A conversion that ends while the pair is locked is discarded, so the later byte reads return the earlier result.
- R6: A conversion whose result is discarded by the lock still sets the completion flag.
- R7: With select bit7 clear (the reset value), the 16-bit pair holds the code right-aligned (high byte = code[9:8]). With bit7 set, the pair holds the code shifted left by 6 (high byte = code[9:2], low byte = code[1:0] followed by six zeros).
- R8: `eng_chan` takes the select register's channel value only at a conversion start. A select write during a conversion leaves `eng_chan` unchanged until the next start.
- R9: In free-running mode (control bit2), `eng_start` pulses in the same cycle that the flag rises. A channel written after that point is used first by the conversion after next.
- R10: The result carries the captured 10-bit code unchanged over its full range: 0x000 and 0x3FF read back exactly.
- R11: After reset, control and select read 0x00, and `irq` and `eng_start` are 0.
- R12: In single mode, each start gives exactly one `eng_start` pulse. The busy bit (control bit1) returns to 0 after the conversion ends, and no further conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; also triggers the result lock and unlock |
| bus_rdata | output | 8 | Registered read data |
| gie | input | 1 | Global interrupt enable from the processor |
| irq_ack | input | 1 | Interrupt vector acknowledge; clears the flag |
| irq | output | 1 | Conversion-complete interrupt request |
| analog_in | input | 10 | Code the stub engine captures at each conversion start |
| eng_start | output | 1 | Start pulse to the conversion engine |
| eng_chan | output | 3 | Channel applied to the engine |

## Verification
The bench lets a conversion end while the pair is locked. A block without the lock would return a high byte that disagrees with the low byte, and a block that also drops the flag would leave software waiting. It rewrites the channel in mid-conversion and right after a free-running flag; a design that forwarded the select register directly would change `eng_chan` under a running conversion or one conversion early. Conversion latency is measured for several prescaler codes, which exposes a wrong divide table or an off-by-one in the tick count. A control write with the flag bit at 0 is also sent, which catches a flag that clears on any write.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int PRESC_W = 3;
  localparam int PCNT_W  = (1 << PRESC_W) - 1;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SEL  = 2'd1;
  localparam logic [1:0] A_RLO  = 2'd2;
  localparam logic [1:0] A_RHI  = 2'd3;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               ie;
    logic               flag;
    logic               frun;
    logic               busy;
    logic               en;
  } ctrl_t;

  // terminal count of the prescaler counter: divide factor minus one
  function automatic logic [PCNT_W-1:0] div_last(input logic [PRESC_W-1:0] code);
    logic [PCNT_W:0] d;
    d = (code == '0) ? (PCNT_W+1)'(2) : (PCNT_W+1)'(1) << code;
    return PCNT_W'(d - 1'b1);
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
  import adc_regif_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               clr,
  input  logic [PRESC_W-1:0] code,
  output logic               tick
);
  logic [PCNT_W-1:0] cnt_q;
  logic [PCNT_W-1:0] last;

  assign last = div_last(code);
  assign tick = en && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !en || clr) cnt_q <= '0;
    else if (cnt_q == last) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_stub_engine.sv
module adc_stub_engine #(
  parameter int DATA_W     = 10,
  parameter int CONV_TICKS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              tick,
  input  logic [DATA_W-1:0] ain,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int CW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || !en) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      if (rst) result <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      result <= ain;
    end else if (busy && tick) begin
      if (cnt_q == CW'(CONV_TICKS-1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int CHAN_W     = 3,
  parameter int CONV_TICKS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              gie,
  input  logic              irq_ack,
  output logic              irq,
  input  logic [DATA_W-1:0] analog_in,
  output logic              eng_start,
  output logic [CHAN_W-1:0] eng_chan
);
  localparam int PAIR_W = 16;
  localparam int PAD_W  = PAIR_W - DATA_W;

  logic               en_q, frun_q, ie_q, flag_q, sc_q, lock_q;
  logic [PRESC_W-1:0] presc_q;
  logic [7:0]         sel_q;
  logic [DATA_W-1:0]  res_q;
  logic [PAIR_W-1:0]  pair;
  ctrl_t              wctl, rctl;
  logic               wr_ctrl, wr_sel, rd_lo, rd_hi;
  logic               tick, eng_busy, eng_done;
  logic [DATA_W-1:0]  eng_result;
  logic [CHAN_W-1:0]  sel_chan;

  assign wctl     = ctrl_t'(bus_wdata);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_sel   = bus_wr && (bus_addr == A_SEL);
  assign rd_lo    = bus_rd && (bus_addr == A_RLO);
  assign rd_hi    = bus_rd && (bus_addr == A_RHI);
  assign sel_chan = sel_q[CHAN_W-1:0];

  adc_prescaler u_presc (
    .clk (clk),
    .rst (rst),
    .en  (en_q),
    .clr (eng_start),
    .code(presc_q),
    .tick(tick)
  );

  adc_stub_engine #(.DATA_W(DATA_W), .CONV_TICKS(CONV_TICKS)) u_eng (
    .clk   (clk),
    .rst   (rst),
    .en    (en_q),
    .start (eng_start),
    .tick  (tick),
    .ain   (analog_in),
    .busy  (eng_busy),
    .done  (eng_done),
    .result(eng_result)
  );

  // control bits, conversion sequencing and the channel handed to the engine
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      frun_q    <= 1'b0;
      ie_q      <= 1'b0;
      presc_q   <= '0;
      sc_q      <= 1'b0;
      eng_start <= 1'b0;
      eng_chan  <= '0;
      sel_q     <= '0;
    end else begin
      eng_start <= 1'b0;
      if (wr_sel) sel_q <= bus_wdata;
      if (wr_ctrl) begin
        en_q    <= wctl.en;
        frun_q  <= wctl.frun;
        ie_q    <= wctl.ie;
        presc_q <= wctl.presc;
        if (!wctl.en) begin
          sc_q <= 1'b0;
        end else if (wctl.busy && !sc_q) begin
          sc_q      <= 1'b1;
          eng_start <= 1'b1;
          eng_chan  <= sel_chan;
        end
      end
      if (eng_done) begin
        if (frun_q && en_q) begin
          eng_start <= 1'b1;
          eng_chan  <= sel_chan;
        end else begin
          sc_q <= 1'b0;
        end
      end
    end
  end

  // completion flag, result lock and result pair
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      lock_q <= 1'b0;
      res_q  <= '0;
    end else begin
      if (eng_done) flag_q <= 1'b1;
      else if (irq_ack || (wr_ctrl && wctl.flag)) flag_q <= 1'b0;

      if (rd_lo) lock_q <= 1'b1;
      else if (rd_hi) lock_q <= 1'b0;

      if (eng_done && !rd_lo && !(lock_q && !rd_hi)) res_q <= eng_result;
    end
  end

  assign pair = sel_q[7] ? {res_q, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, res_q};

  always_comb begin
    rctl       = '0;
    rctl.presc = presc_q;
    rctl.ie    = ie_q;
    rctl.flag  = flag_q;
    rctl.frun  = frun_q;
    rctl.busy  = sc_q;
    rctl.en    = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= rctl;
        A_SEL:   bus_rdata <= sel_q;
        A_RLO:   bus_rdata <= pair[7:0];
        default: bus_rdata <= pair[15:8];
      endcase
    end
  end

  assign irq = flag_q && ie_q && gie;
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int DATA_W = 10,
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              eng_done,
  input logic              flag_q,
  input logic              irq_ack,
  input logic              lock_q,
  input logic              rd_hi,
  input logic [DATA_W-1:0] res_q,
  input logic              frun_q,
  input logic              en_q,
  input logic              eng_start,
  input logic [CHAN_W-1:0] eng_chan
);
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> flag_q); // R1
  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_ack && !eng_done |=> !flag_q); // R2
  AST_LOCK_FREEZES_PAIR: assert property (@(posedge clk) disable iff (rst)
    lock_q && !rd_hi |=> $stable(res_q)); // R5
  AST_CHAN_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(eng_chan) |-> eng_start); // R8
  AST_FREERUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    eng_done && frun_q && en_q |=> eng_start); // R9
  AST_START_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start); // R12
endmodule

bind adc_regif adc_regif_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .eng_done (eng_done),
  .flag_q   (flag_q),
  .irq_ack  (irq_ack),
  .lock_q   (lock_q),
  .rd_hi    (rd_hi),
  .res_q    (res_q),
  .frun_q   (frun_q),
  .en_q     (en_q),
  .eng_start(eng_start),
  .eng_chan (eng_chan)
);

// File: tb/tb_adc_regif.sv
`timescale 1ns/1ps
module tb_adc_regif;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b1;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic [9:0] analog_in = '0;
  logic       eng_start;
  logic [2:0] eng_chan;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_regif dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .gie(gie), .irq_ack(irq_ack), .irq(irq), .analog_in(analog_in),
    .eng_start(eng_start), .eng_chan(eng_chan)
  );

  always @(posedge clk) if (!rst && eng_start) starts <= starts + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!irq && n < 5000);
  endtask

  function automatic int divf(input int code);
    return (code == 0) ? 2 : (1 << code);
  endfunction

  function automatic logic [15:0] pairf(input logic [9:0] v, input bit adj);
    return adj ? {v, 6'b0} : {6'b0, v};
  endfunction

  // control byte: {presc, ie, flag, frun, start, en}
  function automatic logic [7:0] ctl(input int p, input bit ie, input bit fl,
                                     input bit fr, input bit st, input bit en);
    return {p[2:0], ie, fl, fr, st, en};
  endfunction

  task automatic run_single(input logic [9:0] v, input int p, output int n);
    analog_in = v;
    wr(2'd0, ctl(p, 1, 1, 0, 1, 1));
    wait_irq(n);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 irq after reset", irq, 0);
    chk("R11 eng_start after reset", eng_start, 0);
    rd(2'd0, d); chk("R11 control after reset", d, 8'h00);
    rd(2'd1, d); chk("R11 select after reset", d, 8'h00);
  endtask

  task automatic t_prescale();
    int codes[4] = '{0, 1, 3, 7};
    logic [7:0] d;
    int n, s0;
    foreach (codes[i]) begin
      s0 = starts;
      run_single(10'h100 + 10'(i), codes[i], n);
      chk($sformatf("R4 latency code %0d", codes[i]), n, 13 * divf(codes[i]) + 2);
      chk("R1 flag bit set", irq, 1);
      rd(2'd0, d);
      chk("R12 busy clear after single", d[1], 0);
      repeat (40) @(negedge clk);
      chk("R12 single start count", starts - s0, 1);
    end
  endtask

  task automatic t_clear();
    logic [7:0] d;
    int n;
    run_single(10'h011, 0, n);
    wr(2'd0, ctl(0, 1, 0, 0, 0, 1));
    rd(2'd0, d); chk("R2 write 0 keeps flag", d[3], 1);
    ack();
    rd(2'd0, d); chk("R2 ack clears flag", d[3], 0);
    run_single(10'h012, 0, n);
    wr(2'd0, ctl(0, 1, 1, 0, 0, 1));
    rd(2'd0, d); chk("R2 write 1 clears flag", d[3], 0);
  endtask

  task automatic t_irq();
    int n;
    run_single(10'h013, 0, n);
    chk("R3 irq all set", irq, 1);
    gie = 1'b0; @(negedge clk);
    chk("R3 irq gie low", irq, 0);
    gie = 1'b1;
    wr(2'd0, ctl(0, 0, 0, 0, 0, 1));
    chk("R3 irq enable low", irq, 0);
    wr(2'd0, ctl(0, 1, 0, 0, 0, 1));
    chk("R3 irq enable back", irq, 1);
    ack();
    chk("R3 irq flag low", irq, 0);
  endtask

  task automatic t_format();
    logic [9:0] vals[3] = '{10'h3FF, 10'h000, 10'h2A5};
    logic [7:0] lo, hi;
    logic [15:0] e;
    int n;
    for (int adj = 0; adj < 2; adj++) begin
      wr(2'd1, adj ? 8'h80 : 8'h00);
      foreach (vals[i]) begin
        run_single(vals[i], 0, n);
        rd(2'd2, lo); rd(2'd3, hi);
        e = pairf(vals[i], adj[0]);
        chk($sformatf("R7 R10 low byte adj %0d", adj), lo, e[7:0]);
        chk($sformatf("R7 R10 high byte adj %0d", adj), hi, e[15:8]);
      end
    end
    wr(2'd1, 8'h00);
  endtask

  task automatic t_lock();
    logic [7:0] lo, hi;
    int n;
    run_single(10'h155, 0, n);
    rd(2'd2, lo); chk("R5 first low", lo, 8'h55);
    run_single(10'h2AA, 0, n);
    chk("R6 flag set while locked", irq, 1);
    rd(2'd2, lo); chk("R5 low held", lo, 8'h55);
    rd(2'd3, hi); chk("R5 high matches held", hi, 8'h01);
    rd(2'd2, lo); chk("R5 discarded result not written", lo, 8'h55);
    rd(2'd3, hi);
    run_single(10'h2AA, 0, n);
    rd(2'd2, lo); rd(2'd3, hi);
    chk("R5 unlocked low", lo, 8'hAA);
    chk("R5 unlocked high", hi, 8'h02);
  endtask

  task automatic t_chan();
    int n;
    wr(2'd1, 8'h02);
    analog_in = 10'h001;
    wr(2'd0, ctl(0, 1, 1, 0, 1, 1));
    repeat (3) @(negedge clk);
    wr(2'd1, 8'h05);
    chk("R8 channel held in conversion", eng_chan, 2);
    wait_irq(n);
    chk("R8 channel held after end", eng_chan, 2);
    run_single(10'h002, 0, n);
    chk("R8 channel applied at next start", eng_chan, 5);
  endtask

  task automatic t_freerun();
    int n;
    wr(2'd1, 8'h01);
    analog_in = 10'h0F0;
    wr(2'd0, ctl(0, 1, 1, 1, 1, 1));
    wait_irq(n);
    chk("R9 restart with flag", eng_start, 1);
    chk("R9 first restart channel", eng_chan, 1);
    wr(2'd1, 8'h06);
    ack();
    chk("R9 running conversion keeps channel", eng_chan, 1);
    wait_irq(n);
    chk("R9 second restart with flag", eng_start, 1);
    chk("R9 new channel after next", eng_chan, 6);
    wr(2'd0, 8'h00);
    ack();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_clear();
    t_irq();
    t_format();
    t_lock();
    t_chan();
    t_freerun();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule